// File: doc/BRIEF.md
# Scratch RAM Window Mapper

This block serves a fixed 64 MB window of the processor address space, 0x7C000000 up to but not including 0x80000000, from two 4 KB pages of scratch RAM. These pages are the parts of the operand cache data array that stay usable when the cache runs in RAM mode. A request carries an address, a direction and an access size: byte, halfword, long or 32-byte burst. The block decodes the address and picks one of the two pages. It then performs the access, with byte-lane masking on writes and sign extension on narrow reads.

The page choice depends on an index-mode input. In the fine mode, address bit 13 picks the page, so 4 KB blocks alternate in pairs: page 0, page 0, page 1, page 1. In the coarse mode, address bit 25 splits the window into a lower half for page 0 and an upper half for page 1. When the RAM-enable input is low, any access inside the window is unmapped. It then raises an error pulse and has no effect on the pages. Requests outside the window are ignored.

Top module: `ocr_scratch_map`

## Requirements
- R1: Only requests whose address bits 31:26 equal 6'b011111 (0x7C000000 to 0x7FFFFFFF) get a response. Any other request produces neither rsp_valid nor rsp_err and changes no stored byte.
- R2: With index_mode = 0, address bit 13 selects the page: 0 selects page 0 and 1 selects page 1.
- R3: With index_mode = 1, address bit 25 selects the page: addresses below 0x7E000000 use page 0 and addresses at or above it use page 1.
- R4: The byte within a page is address bits 11:0. Address bits that neither pick the page nor the offset are ignored, so such addresses alias.
- R5: A long access (req_size = 2) reads or writes the aligned 32-bit word, ignoring address bits 1:0. Byte k of the word sits in data bits 8k+7:8k (little-endian).
- R6: A halfword access (req_size = 1) uses address bit 1 to pick the lane pair: 0 for bits 15:0 and 1 for bits 31:16. Address bit 0 is ignored. A write changes only those two bytes, taking them from req_wdata[15:0]. A read returns the halfword sign-extended to 32 bits.
- R7: A byte access (req_size = 0) uses address bits 1:0 to pick the byte lane. A write changes only that byte, taking it from req_wdata[7:0]. A read returns the byte sign-extended to 32 bits.
- R8: A burst access (req_size = 3) moves the 32 bytes starting at page offset {bits 11:5, 5'b0}, ignoring address bits 4:0. Byte k of the burst is carried on bits 8k+7:8k of req_wburst or rsp_rburst.
- R9: While ram_enable = 0, a request inside the window raises rsp_err for one cycle and changes no stored byte. A read request also returns rsp_valid with rsp_rdata and rsp_rburst at zero.
- R10: rsp_valid pulses in the cycle after each read request inside the window. Writes produce no rsp_valid.
- R11: During and straight after reset, rsp_valid and rsp_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 long, 3 burst |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data for byte, halfword and long |
| req_wburst | input | 256 | Write data for burst |
| ram_enable | input | 1 | RAM mode active |
| index_mode | input | 1 | 0 = page by bit 13, 1 = page by bit 25 |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read data for byte, halfword and long |
| rsp_rburst | output | 256 | Read data for burst |
| rsp_err | output | 1 | Unmapped access pulse |

## Verification
Every result of this block arrives exactly one clock after the request: the read word or line, the valid strobe and the error pulse. Write effects show up on the next read. The driver presents each request on a falling edge and queues the response it expects. The monitor wakes 1 ns after each rising edge and compares outputs against the head of the queue, which holds the item pushed at the falling edge before that rising edge. When the queue is empty, that cycle must show neither valid nor error. Writes that should be ignored are checked by reading the same page bytes back afterwards.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_BURST = 2'd3
  } acc_size_e;

  // Byte lanes touched by a single (non-burst) access, little-endian.
  function automatic logic [3:0] lane_mask(acc_size_e sz, logic [1:0] lo);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << lo;
      SZ_HALF: lane_mask = lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Replicate narrow write data onto every lane so the mask picks it.
  function automatic logic [31:0] lane_spread(acc_size_e sz, logic [31:0] wd);
    case (sz)
      SZ_BYTE: lane_spread = {4{wd[7:0]}};
      SZ_HALF: lane_spread = {2{wd[15:0]}};
      default: lane_spread = wd;
    endcase
  endfunction

  // Extract and sign-extend the addressed part of a stored word.
  function automatic logic [31:0] lane_pick(acc_size_e sz, logic [1:0] lo, logic [31:0] w);
    logic [31:0] sh;
    sh = w >> {lo, 3'b000};
    case (sz)
      SZ_BYTE: lane_pick = {{24{sh[7]}}, sh[7:0]};
      SZ_HALF: lane_pick = lo[1] ? {{16{w[31]}}, w[31:16]} : {{16{w[15]}}, w[15:0]};
      default: lane_pick = w;
    endcase
  endfunction
endpackage

// File: rtl/ocr_decode.sv
module ocr_decode #(
  parameter int          ADDR_W      = 32,
  parameter int          REGION_AW   = 26,
  parameter int          PAGE_AW     = 12,
  parameter logic [31:0] REGION_BASE = 32'h7C00_0000
) (
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               ram_enable,
  input  logic               index_mode,
  output logic               hit,
  output logic               live,
  output logic               page,
  output logic [PAGE_AW-1:0] off
);
  localparam int COARSE_BIT = REGION_AW - 1;
  localparam int FINE_BIT   = PAGE_AW + 1;

  logic in_window;
  logic addr_unused;

  assign in_window   = addr[ADDR_W-1:REGION_AW] == REGION_BASE[ADDR_W-1:REGION_AW];
  assign hit         = req_valid && in_window;
  assign live        = hit && ram_enable;
  assign page        = index_mode ? addr[COARSE_BIT] : addr[FINE_BIT];
  assign off         = addr[PAGE_AW-1:0];
  assign addr_unused = ^{addr[COARSE_BIT-1:FINE_BIT+1], addr[PAGE_AW]};
endmodule

// File: rtl/ocr_bank.sv
module ocr_bank #(
  parameter int ROW_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [3:0]        be,
  input  logic [ROW_AW-1:0] row,
  input  logic [31:0]       wdata,
  output logic [31:0]       q
);
  localparam int ROWS = 1 << ROW_AW;

  logic [31:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) mem[row][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    q <= mem[row];
  end
endmodule

// File: rtl/ocr_scratch_map.sv
module ocr_scratch_map #(
  parameter int          ADDR_W      = 32,
  parameter int          REGION_AW   = 26,
  parameter int          PAGE_AW     = 12,
  parameter int          LANES       = 8,
  parameter logic [31:0] REGION_BASE = 32'h7C00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [255:0]      req_wburst,
  input  logic              ram_enable,
  input  logic              index_mode,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [255:0]      rsp_rburst,
  output logic              rsp_err
);
  import ocr_pkg::*;

  localparam int WORD_AW = PAGE_AW - 2;
  localparam int LANE_AW = $clog2(LANES);
  localparam int ROW_AW  = WORD_AW - LANE_AW + 1;

  logic               hit, live, page;
  logic [PAGE_AW-1:0] off;
  acc_size_e          sz;
  logic [WORD_AW-1:0] word;
  logic [LANE_AW-1:0] lane;
  logic [ROW_AW-1:0]  row;
  logic [LANES-1:0]   bank_we;
  logic [3:0]         single_be;
  logic [31:0]        single_wd;
  logic [31:0]        q_all [LANES];
  logic [255:0]       line_q;

  logic               rd_q, err_q, live_rd_q;
  acc_size_e          sz_q;
  logic [LANE_AW-1:0] lane_q;
  logic [1:0]         lo_q;

  ocr_decode #(
    .ADDR_W(ADDR_W), .REGION_AW(REGION_AW), .PAGE_AW(PAGE_AW), .REGION_BASE(REGION_BASE)
  ) u_dec (
    .req_valid(req_valid), .addr(req_addr), .ram_enable(ram_enable),
    .index_mode(index_mode), .hit(hit), .live(live), .page(page), .off(off)
  );

  assign sz        = acc_size_e'(req_size);
  assign word      = off[PAGE_AW-1:2];
  assign lane      = word[LANE_AW-1:0];
  assign row       = {page, word[WORD_AW-1:LANE_AW]};
  assign single_be = lane_mask(sz, off[1:0]);
  assign single_wd = lane_spread(sz, req_wdata);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic        we_g;
    logic [3:0]  be_g;
    logic [31:0] wd_g;
    assign we_g       = live && req_write && (sz == SZ_BURST || lane == LANE_AW'(g));
    assign be_g       = (sz == SZ_BURST) ? 4'hF : single_be;
    assign wd_g       = (sz == SZ_BURST) ? req_wburst[32*g +: 32] : single_wd;
    assign bank_we[g] = we_g;
    assign line_q[32*g +: 32] = q_all[g];
    ocr_bank #(.ROW_AW(ROW_AW)) u_bank (
      .clk(clk), .we(we_g), .be(be_g), .row(row), .wdata(wd_g), .q(q_all[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      err_q     <= 1'b0;
      live_rd_q <= 1'b0;
      sz_q      <= SZ_LONG;
      lane_q    <= '0;
      lo_q      <= '0;
    end else begin
      rd_q      <= hit && !req_write;
      err_q     <= hit && !ram_enable;
      live_rd_q <= live && !req_write;
      sz_q      <= sz;
      lane_q    <= lane;
      lo_q      <= off[1:0];
    end
  end

  assign rsp_valid  = rd_q;
  assign rsp_err    = err_q;
  assign rsp_rburst = (live_rd_q && sz_q == SZ_BURST) ? line_q : '0;
  assign rsp_rdata  = (live_rd_q && sz_q != SZ_BURST) ? lane_pick(sz_q, lo_q, q_all[lane_q]) : '0;

  // R10: a read inside the window is answered on the next cycle
  a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !req_write |=> rsp_valid);
  // R10: no response strobe without a read one cycle earlier
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R1: requests outside the window stay silent
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hit |=> !rsp_valid && !rsp_err);
  // R9: unmapped access never writes a bank and reads back zero
  a_r9_no_write_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !ram_enable |-> bank_we == '0);
  a_r9_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err && rsp_valid |-> rsp_rdata == '0 && rsp_rburst == '0);
  // R5/R6/R7: a single access writes exactly one bank
  a_r5_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    live && req_write && req_size != 2'd3 |-> $onehot(bank_we));
endmodule

// File: tb/sim_ocr_scratch_map.sv
`timescale 1ns/1ps
module sim_ocr_scratch_map;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]   req_size = 2'd2;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic [255:0] req_wburst = '0;
  logic         ram_enable = 1'b1, index_mode = 1'b0;
  logic         rsp_valid, rsp_err;
  logic [31:0]  rsp_rdata;
  logic [255:0] rsp_rburst;

  always #2 clk = ~clk;

  ocr_scratch_map u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wburst(req_wburst), .ram_enable(ram_enable), .index_mode(index_mode),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_rburst(rsp_rburst), .rsp_err(rsp_err)
  );

  typedef struct {
    logic         valid;
    logic         err;
    logic         burst;
    logic [31:0]  data;
    logic [255:0] line;
    string        tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  mdl [int];
  int          checks = 0, errors = 0;
  bit          mon_on = 0;

  function automatic logic [7:0] rdb(int a);
    return mdl.exists(a) ? mdl[a] : 8'h00;
  endfunction

  function automatic int phys(logic [31:0] a);
    logic pg;
    pg = index_mode ? a[25] : a[13];
    return {19'd0, pg, a[11:0]};
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic req(string tag, logic wr, logic [1:0] sz, logic [31:0] a,
                     logic [31:0] wd, logic [255:0] wb);
    exp_t e;
    int p;
    logic inwin;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = a; req_wdata = wd; req_wburst = wb;
    inwin = (a >= 32'h7C00_0000) && (a <= 32'h7FFF_FFFF);
    p = phys(a);
    e.tag = tag; e.burst = (sz == 2'd3);
    e.valid = inwin && !wr;
    e.err = inwin && !ram_enable;
    e.data = '0; e.line = '0;
    if (inwin && ram_enable) begin
      if (wr) begin
        case (sz)
          2'd0: mdl[p] = wd[7:0];
          2'd1: begin mdl[p & ~1] = wd[7:0]; mdl[(p & ~1) + 1] = wd[15:8]; end
          2'd2: for (int k = 0; k < 4; k++) mdl[(p & ~3) + k] = wd[8*k +: 8];
          default: for (int k = 0; k < 32; k++) mdl[(p & ~31) + k] = wb[8*k +: 8];
        endcase
      end else begin
        case (sz)
          2'd0: e.data = {{24{rdb(p)[7]}}, rdb(p)};
          2'd1: e.data = {{16{rdb((p & ~1) + 1)[7]}}, rdb((p & ~1) + 1), rdb(p & ~1)};
          2'd2: for (int k = 0; k < 4; k++) e.data[8*k +: 8] = rdb((p & ~3) + k);
          default: for (int k = 0; k < 32; k++) e.line[8*k +: 8] = rdb((p & ~31) + k);
        endcase
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: results are due one clock after the request edge.
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      exp_t e;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " valid"}, {255'd0, rsp_valid}, {255'd0, e.valid});
        check({e.tag, " err"}, {255'd0, rsp_err}, {255'd0, e.err});
        if (e.valid) begin
          if (e.burst) check({e.tag, " line"}, rsp_rburst, e.line);
          else         check({e.tag, " data"}, {224'd0, rsp_rdata}, {224'd0, e.data});
        end
      end else if (rsp_valid || rsp_err) begin
        check("R10 idle cycle quiet", {254'd0, rsp_valid, rsp_err}, '0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] pat;
    for (int k = 0; k < 32; k++) pat[8*k +: 8] = 8'hA0 + 8'(k);
    idle(1);
    check("R11 reset valid/err", {254'd0, rsp_valid, rsp_err}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", {254'd0, rsp_valid, rsp_err}, '0);
    mon_on = 1;

    // R2 fine index mode, R5 long
    index_mode = 1'b0;
    req("R5 wr p0", 1, 2'd2, 32'h7C00_0000, 32'h1122_3344, '0);
    req("R2 wr p1", 1, 2'd2, 32'h7C00_2000, 32'hAABB_CCDD, '0);
    req("R5 rd p0", 0, 2'd2, 32'h7C00_0003, '0, '0);
    req("R2 rd p1", 0, 2'd2, 32'h7C00_2000, '0, '0);
    req("R4 alias bit12", 0, 2'd2, 32'h7C00_1000, '0, '0);
    req("R2 bit13 block3", 0, 2'd2, 32'h7C00_3000, '0, '0);
    req("R4 alias high", 0, 2'd2, 32'h7DF0_6000, '0, '0);
    idle(2);
    // R3 coarse index mode
    index_mode = 1'b1;
    req("R3 low half", 0, 2'd2, 32'h7C00_0000, '0, '0);
    req("R3 upper half", 0, 2'd2, 32'h7E00_0000, '0, '0);
    req("R3 bit13 ignored", 0, 2'd2, 32'h7C00_2000, '0, '0);
    req("R3 top of low", 0, 2'd2, 32'h7DFF_F000, '0, '0);
    req("R3 wr upper", 1, 2'd2, 32'h7FFF_F010, 32'h0BAD_F00D, '0);
    req("R3 rd upper", 0, 2'd2, 32'h7E00_0010, '0, '0);
    idle(1);
    index_mode = 1'b0;
    // R6 halfword
    req("R6 wr half lo", 1, 2'd1, 32'h7C00_0104, 32'hFFFF_8001, '0);
    req("R6 wr half hi", 1, 2'd1, 32'h7C00_0107, 32'h5555_1234, '0);
    req("R6 rd long", 0, 2'd2, 32'h7C00_0104, '0, '0);
    req("R6 rd half neg", 0, 2'd1, 32'h7C00_0104, '0, '0);
    req("R6 rd half pos", 0, 2'd1, 32'h7C00_0106, '0, '0);
    // R7 byte
    req("R7 wr b0", 1, 2'd0, 32'h7C00_0108, 32'h0000_007F, '0);
    req("R7 wr b1", 1, 2'd0, 32'h7C00_0109, 32'h0000_0080, '0);
    req("R7 wr b2", 1, 2'd0, 32'h7C00_010A, 32'h0000_0001, '0);
    req("R7 wr b3", 1, 2'd0, 32'h7C00_010B, 32'h0000_00FE, '0);
    req("R7 rd long", 0, 2'd2, 32'h7C00_0108, '0, '0);
    req("R7 rd b1 neg", 0, 2'd0, 32'h7C00_0109, '0, '0);
    req("R7 rd b0 pos", 0, 2'd0, 32'h7C00_0108, '0, '0);
    req("R7 rd b3 neg", 0, 2'd0, 32'h7C00_010B, '0, '0);
    // R8 burst
    req("R8 wr burst", 1, 2'd3, 32'h7C00_2200, '0, pat);
    req("R8 rd burst unaligned", 0, 2'd3, 32'h7C00_2213, '0, '0);
    req("R8 rd word in line", 0, 2'd2, 32'h7C00_2214, '0, '0);
    req("R8 wr byte in line", 1, 2'd0, 32'h7C00_221F, 32'h0000_0042, '0);
    req("R8 rd burst again", 0, 2'd3, 32'h7C00_2200, '0, '0);
    idle(2);
    // R9 disabled
    ram_enable = 1'b0;
    req("R9 rd unmapped", 0, 2'd2, 32'h7C00_0000, '0, '0);
    req("R9 wr unmapped", 1, 2'd2, 32'h7C00_0000, 32'hDEAD_BEEF, '0);
    req("R9 burst unmapped", 0, 2'd3, 32'h7C00_2200, '0, '0);
    idle(1);
    ram_enable = 1'b1;
    req("R9 write had no effect", 0, 2'd2, 32'h7C00_0000, '0, '0);
    // R1 outside window
    req("R1 rd above", 0, 2'd2, 32'h8000_0000, '0, '0);
    req("R1 wr below", 1, 2'd2, 32'h7BFF_F000, 32'h7777_7777, '0);
    req("R1 rd below", 0, 2'd2, 32'h7BFF_FFFC, '0, '0);
    req("R1 no alias write", 0, 2'd2, 32'h7C00_0000, '0, '0);
    idle(4);
    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule